// File: doc/BRIEF.md
# DMA Channel Register and Control Unit

This block is the software-facing control slice of one DMA channel. It decodes word-wide register accesses inside the channel's address window, holds the channel's reset/stopped/running state and its descriptor pointers, and drives descriptor-fetch and start strobes towards a separate transfer engine. That engine fetches descriptors from memory, returns the fields this unit needs, and reports end-of-list and interrupt events back.

Software begins a transfer by writing the stream-command register, which can fetch a data descriptor, fetch a context descriptor, or do both. After the engine has stopped at an end-of-list descriptor, software can clear that flag in memory and write the command register to resume. The unit then fetches the current descriptor again and, if the flag is now clear, fetches the following one and restarts. Interrupt sources are collected in a raw status register, filtered by a mask, and cleared through a write-only acknowledge register. The masked result drives a single interrupt line.

Top module: `dma_chan_ctrl`

## Requirements
- R1: An access is accepted only when the size code is 2 (32-bit) and address bits [ADDR_W-1:13] equal CH_ID. Any other request gets a response with the error flag set, read data 0, and no change of state. Every request is answered by the response strobe exactly one cycle later, and there is no response without a request.
- R2: Register offsets are taken from address bits [7:0]. Data pointer 0x00, saved descriptor pointer 0x58, saved buffer pointer 0x5C, group 0x60 and group-down 0x7C read back the 32-bit value last written. The mask at 0x8C reads back its low INTR_W bits. Writes to status 0x88, raw 0x94 and masked 0x98 are ignored, and unmapped offsets read 0 and ignore writes.
- R3: The channel state is one of RST=1, STOPPED=2 and RUNNING=4, and it is RST after reset. A configuration write (0x84) with bit 1 set selects STOPPED. A configuration write with bit 0 clear selects RST, and RST wins when both apply.
- R4: The status word at 0x88 carries the state in bits [2:0], the reached-end-of-list flag in bit 5, and the source field, which holds 1, in bits [9:8]. It reads 0x101 after reset.
- R5: A stream-command write (0x9C) whose low 10 bits contain both bit 8 and bit 6 pulses the data-fetch strobe at the saved descriptor pointer and copies that address into the data pointer. If bit 5 is also set, the channel starts when the fetch completes.
- R6: A stream-command write with bit 9 set pulses the context-fetch strobe at the group-down pointer. On completion the two returned pointers become the saved descriptor pointer and the saved buffer pointer, and the channel starts. When bits 8, 6 and 9 are all set, the data fetch comes first.
- R7: A start with the client present clears the end-of-list flag, enters RUNNING and pulses the start strobe. Without a client, a start changes nothing.
- R8: A command write (0x80) with bit 0 set fetches the current descriptor again only if all of these hold: configuration bit 0 is set, configuration bit 1 is clear, the client is present, the state is RUNNING, and the last fetched descriptor had end-of-list set. Otherwise nothing happens.
- R9: If the descriptor fetched again has end-of-list clear and the channel had reached end-of-list, the unit copies the next pointer into the saved and data pointers, fetches that descriptor, and starts the channel. In every continue, the saved buffer pointer takes the buffer start of the last descriptor fetched.
- R10: Writing the acknowledge register (0x90) clears the written bits of raw status. Engine interrupt events set raw bits, and the acknowledge register always reads 0.
- R11: Offset 0x98 reads raw AND mask, and the interrupt output is high exactly when that value is non-zero.
- R12: An end-of-list report from the engine sets the reached-end-of-list flag and marks the current descriptor as end-of-list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Single-cycle access request |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_size_i | input | 2 | Access size code (2 = 32-bit) |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Response strobe, one cycle after the request |
| bus_err_o | output | 1 | Response carries an error |
| bus_rdata_o | output | 32 | Read data with the response |
| client_i | input | 1 | A client is attached to the channel |
| eng_load_d_o | output | 1 | Data-descriptor fetch strobe |
| eng_load_c_o | output | 1 | Context-descriptor fetch strobe |
| eng_addr_o | output | 32 | Descriptor address for the fetch |
| eng_start_o | output | 1 | Channel start strobe |
| eng_done_i | input | 1 | The outstanding fetch has completed |
| eng_d_eol_i | input | 1 | End-of-list flag of the fetched data descriptor |
| eng_ptr0_i | input | 32 | Next pointer (data) or saved descriptor pointer (context) |
| eng_ptr1_i | input | 32 | Buffer start (data) or saved buffer pointer (context) |
| eng_eol_i | input | 1 | Engine reached an end-of-list descriptor |
| eng_intr_i | input | INTR_W | Interrupt events to set in raw status |
| irq_o | output | 1 | Masked interrupt line |

## Verification
A bus response, and any register value it reads back, appears one cycle after the request edge. Fetch strobes and the fetch address are registered at the edge that accepts the command write, so they are visible from the half cycle that follows it. The start strobe, state and pointer updates appear one cycle after the completion edge, and the interrupt line follows a raw, mask or acknowledge change by one cycle. The bench drives every input on the falling edge and samples only on the following falling edge, once the register for that result has been updated. Status and pointers are read back over the bus after each sequence.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CH_SHIFT = 13;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [7:0] OFS_DPTR   = 8'h00;
  localparam logic [7:0] OFS_SVD    = 8'h58;
  localparam logic [7:0] OFS_SVB    = 8'h5C;
  localparam logic [7:0] OFS_GROUP  = 8'h60;
  localparam logic [7:0] OFS_GDOWN  = 8'h7C;
  localparam logic [7:0] OFS_CMD    = 8'h80;
  localparam logic [7:0] OFS_CFG    = 8'h84;
  localparam logic [7:0] OFS_STAT   = 8'h88;
  localparam logic [7:0] OFS_MASK   = 8'h8C;
  localparam logic [7:0] OFS_ACK    = 8'h90;
  localparam logic [7:0] OFS_RAW    = 8'h94;
  localparam logic [7:0] OFS_MASKED = 8'h98;
  localparam logic [7:0] OFS_STREAM = 8'h9C;

  localparam logic [9:0] LD_DATA_PAT = 10'h140;
  localparam int LD_CTX_BIT = 9;
  localparam int BURST_BIT  = 5;
  localparam logic [1:0] SRC_FIELD = 2'd1;

  typedef enum logic [2:0] {
    CH_RST  = 3'd1,
    CH_STOP = 3'd2,
    CH_RUN  = 3'd4
  } ch_state_e;

  typedef enum logic [2:0] {
    Q_IDLE, Q_SDATA, Q_SCTX, Q_KFIRST, Q_KNEXT
  } seq_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DPTR, SEL_SVD, SEL_SVB, SEL_GROUP, SEL_GDOWN, SEL_CMD,
    SEL_CFG, SEL_STAT, SEL_MASK, SEL_ACK, SEL_RAW, SEL_MASKED, SEL_STREAM
  } reg_sel_e;

  function automatic logic [31:0] status_word(input logic [2:0] st,
                                              input logic eol,
                                              input logic [1:0] src);
    return {22'd0, src, 2'd0, eol, 2'd0, st};
  endfunction

  function automatic logic wants_data_load(input logic [9:0] c);
    return (c & LD_DATA_PAT) == LD_DATA_PAT;
  endfunction

endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CH_ID  = 0
) (
  input  logic              req_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              fault_o,
  output reg_sel_e          sel_o
);
  localparam int CH_W = ADDR_W - CH_SHIFT;

  logic [CH_W-1:0] chan;
  logic            unused_addr;

  assign chan        = addr_i[ADDR_W-1:CH_SHIFT];
  assign unused_addr = ^addr_i[CH_SHIFT-1:8];
  assign hit_o       = req_i && (size_i == SIZE_WORD) && (chan == CH_W'(CH_ID));
  assign fault_o     = req_i && !hit_o;

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      case (addr_i[7:0])
        OFS_DPTR:   sel_o = SEL_DPTR;
        OFS_SVD:    sel_o = SEL_SVD;
        OFS_SVB:    sel_o = SEL_SVB;
        OFS_GROUP:  sel_o = SEL_GROUP;
        OFS_GDOWN:  sel_o = SEL_GDOWN;
        OFS_CMD:    sel_o = SEL_CMD;
        OFS_CFG:    sel_o = SEL_CFG;
        OFS_STAT:   sel_o = SEL_STAT;
        OFS_MASK:   sel_o = SEL_MASK;
        OFS_ACK:    sel_o = SEL_ACK;
        OFS_RAW:    sel_o = SEL_RAW;
        OFS_MASKED: sel_o = SEL_MASKED;
        OFS_STREAM: sel_o = SEL_STREAM;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int INTR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              ack_we_i,
  input  logic [INTR_W-1:0] wdata_i,
  input  logic [INTR_W-1:0] set_i,
  output logic [INTR_W-1:0] raw_o,
  output logic [INTR_W-1:0] mask_o,
  output logic [INTR_W-1:0] masked_o,
  output logic              irq_o
);
  logic [INTR_W-1:0] clr;

  assign clr      = ack_we_i ? wdata_i : '0;
  assign masked_o = raw_o & mask_o;
  assign irq_o    = |masked_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      mask_o <= '0;
    end else begin
      raw_o <= (raw_o & ~clr) | set_i;
      if (mask_we_i) mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        client_i,
  input  logic [1:0]  cfg_i,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_wdata_i,
  input  logic        cmd_we_i,
  input  logic        cmd_go_i,
  input  logic        strm_we_i,
  input  logic [9:0]  strm_cmd_i,
  input  logic [2:0]  ptr_we_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] gdown_i,
  input  logic        done_i,
  input  logic        d_eol_i,
  input  logic [31:0] ptr0_i,
  input  logic [31:0] ptr1_i,
  input  logic        eng_eol_i,
  output ch_state_e   state_o,
  output logic        eol_o,
  output logic [31:0] dptr_o,
  output logic [31:0] svd_o,
  output logic [31:0] svb_o,
  output logic        load_d_o,
  output logic        load_c_o,
  output logic [31:0] addr_o,
  output logic        start_o,
  output logic        cont_go_o,
  output logic        resume_o
);
  seq_e seq_q;
  logic cur_eol_q, pend_c_q, pend_start_q;
  logic ld_d_req, ld_c_req, start_req, start_ok;

  always_comb begin
    ld_d_req  = strm_we_i && wants_data_load(strm_cmd_i);
    ld_c_req  = strm_we_i && strm_cmd_i[LD_CTX_BIT];
    cont_go_o = cmd_we_i && cmd_go_i && (seq_q == Q_IDLE) && cfg_i[0] &&
                !cfg_i[1] && client_i && (state_o == CH_RUN) && cur_eol_q;
    resume_o  = (seq_q == Q_KFIRST) && done_i && !d_eol_i && eol_o;
    start_req = done_i && (((seq_q == Q_SDATA) && pend_start_q) ||
                           (seq_q == Q_SCTX) || (seq_q == Q_KNEXT));
    start_ok  = start_req && client_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q        <= Q_IDLE;
      state_o      <= CH_RST;
      eol_o        <= 1'b0;
      cur_eol_q    <= 1'b0;
      pend_c_q     <= 1'b0;
      pend_start_q <= 1'b0;
      dptr_o       <= '0;
      svd_o        <= '0;
      svb_o        <= '0;
      addr_o       <= '0;
      load_d_o     <= 1'b0;
      load_c_o     <= 1'b0;
      start_o      <= 1'b0;
    end else begin
      load_d_o <= 1'b0;
      load_c_o <= 1'b0;
      start_o  <= start_ok;
      if (ptr_we_i[0]) dptr_o <= wdata_i;
      if (ptr_we_i[1]) svd_o  <= wdata_i;
      if (ptr_we_i[2]) svb_o  <= wdata_i;
      if (eng_eol_i) begin
        eol_o     <= 1'b1;
        cur_eol_q <= 1'b1;
      end
      case (seq_q)
        Q_IDLE: begin
          if (ld_d_req) begin
            load_d_o     <= 1'b1;
            addr_o       <= svd_o;
            dptr_o       <= svd_o;
            pend_c_q     <= ld_c_req;
            pend_start_q <= strm_cmd_i[BURST_BIT];
            seq_q        <= Q_SDATA;
          end else if (ld_c_req) begin
            load_c_o <= 1'b1;
            addr_o   <= gdown_i;
            seq_q    <= Q_SCTX;
          end else if (cont_go_o) begin
            load_d_o <= 1'b1;
            addr_o   <= svd_o;
            dptr_o   <= svd_o;
            seq_q    <= Q_KFIRST;
          end
        end
        Q_SDATA: if (done_i) begin
          cur_eol_q <= d_eol_i;
          if (pend_c_q) begin
            load_c_o <= 1'b1;
            addr_o   <= gdown_i;
            seq_q    <= Q_SCTX;
          end else begin
            seq_q <= Q_IDLE;
          end
        end
        Q_SCTX: if (done_i) begin
          svd_o <= ptr0_i;
          svb_o <= ptr1_i;
          seq_q <= Q_IDLE;
        end
        Q_KFIRST: if (done_i) begin
          cur_eol_q <= d_eol_i;
          if (resume_o) begin
            svd_o    <= ptr0_i;
            dptr_o   <= ptr0_i;
            addr_o   <= ptr0_i;
            load_d_o <= 1'b1;
            seq_q    <= Q_KNEXT;
          end else begin
            svb_o <= ptr1_i;
            seq_q <= Q_IDLE;
          end
        end
        Q_KNEXT: if (done_i) begin
          cur_eol_q <= d_eol_i;
          svb_o     <= ptr1_i;
          seq_q     <= Q_IDLE;
        end
        default: seq_q <= Q_IDLE;
      endcase
      if (start_ok) begin
        eol_o   <= 1'b0;
        state_o <= CH_RUN;
      end
      if (cfg_we_i) begin
        if (cfg_wdata_i[1])  state_o <= CH_STOP;
        if (!cfg_wdata_i[0]) state_o <= CH_RST;
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CH_ID  = 0,
  parameter int INTR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_ack_o,
  output logic              bus_err_o,
  output logic [31:0]       bus_rdata_o,
  input  logic              client_i,
  output logic              eng_load_d_o,
  output logic              eng_load_c_o,
  output logic [31:0]       eng_addr_o,
  output logic              eng_start_o,
  input  logic              eng_done_i,
  input  logic              eng_d_eol_i,
  input  logic [31:0]       eng_ptr0_i,
  input  logic [31:0]       eng_ptr1_i,
  input  logic              eng_eol_i,
  input  logic [INTR_W-1:0] eng_intr_i,
  output logic              irq_o
);
  logic        hit, fault, wr;
  reg_sel_e    sel;
  logic [31:0] group_q, gdown_q, rd_mux;
  logic        cmd_q;
  logic [1:0]  cfg_q;
  logic [9:0]  strm_q;
  logic        cfg_we, cmd_we, strm_we, mask_we, ack_we;
  logic [2:0]  ptr_we;
  ch_state_e   state_q;
  logic        eol_q, cont_go, resume;
  logic [31:0] dptr_q, svd_q, svb_q;
  logic [INTR_W-1:0] raw_q, mask_q, masked;

  dma_chan_decode #(.ADDR_W(ADDR_W), .CH_ID(CH_ID)) u_dec (
    .req_i(bus_req_i), .size_i(bus_size_i), .addr_i(bus_addr_i),
    .hit_o(hit), .fault_o(fault), .sel_o(sel));

  assign wr      = hit && bus_we_i;
  assign cfg_we  = wr && (sel == SEL_CFG);
  assign cmd_we  = wr && (sel == SEL_CMD);
  assign strm_we = wr && (sel == SEL_STREAM);
  assign mask_we = wr && (sel == SEL_MASK);
  assign ack_we  = wr && (sel == SEL_ACK);
  assign ptr_we  = {wr && (sel == SEL_SVB), wr && (sel == SEL_SVD), wr && (sel == SEL_DPTR)};

  dma_chan_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .client_i(client_i), .cfg_i(cfg_q),
    .cfg_we_i(cfg_we), .cfg_wdata_i(bus_wdata_i[1:0]),
    .cmd_we_i(cmd_we), .cmd_go_i(bus_wdata_i[0]),
    .strm_we_i(strm_we), .strm_cmd_i(bus_wdata_i[9:0]),
    .ptr_we_i(ptr_we), .wdata_i(bus_wdata_i), .gdown_i(gdown_q),
    .done_i(eng_done_i), .d_eol_i(eng_d_eol_i), .ptr0_i(eng_ptr0_i),
    .ptr1_i(eng_ptr1_i), .eng_eol_i(eng_eol_i),
    .state_o(state_q), .eol_o(eol_q), .dptr_o(dptr_q), .svd_o(svd_q),
    .svb_o(svb_q), .load_d_o(eng_load_d_o), .load_c_o(eng_load_c_o),
    .addr_o(eng_addr_o), .start_o(eng_start_o), .cont_go_o(cont_go),
    .resume_o(resume));

  dma_chan_irq #(.INTR_W(INTR_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_we_i(mask_we), .ack_we_i(ack_we),
    .wdata_i(bus_wdata_i[INTR_W-1:0]), .set_i(eng_intr_i),
    .raw_o(raw_q), .mask_o(mask_q), .masked_o(masked), .irq_o(irq_o));

  always_comb begin
    case (sel)
      SEL_DPTR:   rd_mux = dptr_q;
      SEL_SVD:    rd_mux = svd_q;
      SEL_SVB:    rd_mux = svb_q;
      SEL_GROUP:  rd_mux = group_q;
      SEL_GDOWN:  rd_mux = gdown_q;
      SEL_CMD:    rd_mux = 32'(cmd_q);
      SEL_CFG:    rd_mux = 32'(cfg_q);
      SEL_STAT:   rd_mux = status_word(state_q, eol_q, SRC_FIELD);
      SEL_MASK:   rd_mux = 32'(mask_q);
      SEL_RAW:    rd_mux = 32'(raw_q);
      SEL_MASKED: rd_mux = 32'(masked);
      SEL_STREAM: rd_mux = 32'(strm_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_q     <= '0;
      gdown_q     <= '0;
      cmd_q       <= 1'b0;
      cfg_q       <= '0;
      strm_q      <= '0;
      bus_ack_o   <= 1'b0;
      bus_err_o   <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      bus_ack_o   <= bus_req_i;
      bus_err_o   <= fault;
      bus_rdata_o <= (hit && !bus_we_i) ? rd_mux : '0;
      if (wr && sel == SEL_GROUP) group_q <= bus_wdata_i;
      if (wr && sel == SEL_GDOWN) gdown_q <= bus_wdata_i;
      if (cmd_we)  cmd_q  <= bus_wdata_i[0];
      if (cfg_we)  cfg_q  <= bus_wdata_i[1:0];
      if (strm_we) strm_q <= bus_wdata_i[9:0];
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int INTR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic [1:0]        bus_size_i,
  input logic              bus_ack_o,
  input logic              bus_err_o,
  input logic              client_i,
  input logic              cfg_we,
  input logic [2:0]        state_q,
  input logic              eng_start_o,
  input logic              eng_load_d_o,
  input logic [31:0]       eng_addr_o,
  input logic [31:0]       dptr_q,
  input logic              ack_we,
  input logic [31:0]       bus_wdata_i,
  input logic [INTR_W-1:0] eng_intr_i,
  input logic [INTR_W-1:0] raw_q,
  input logic              irq_o
);
  assert_narrow_err_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_size_i != 2'd2) |=> (bus_ack_o && bus_err_o));

  assert_no_stray_resp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> (!bus_ack_o && !bus_err_o));

  assert_state_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  assert_start_needs_client_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> $past(client_i));

  assert_start_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && !$past(cfg_we)) |-> (state_q == 3'd4));

  assert_fetch_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_load_d_o |-> (eng_addr_o == dptr_q));

  assert_ack_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we && (&bus_wdata_i[INTR_W-1:0]) && eng_intr_i == '0) |=> (raw_q == '0 && !irq_o));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.INTR_W(INTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_size_i(bus_size_i),
  .bus_ack_o(bus_ack_o), .bus_err_o(bus_err_o), .client_i(client_i),
  .cfg_we(cfg_we), .state_q(state_q), .eng_start_o(eng_start_o),
  .eng_load_d_o(eng_load_d_o), .eng_addr_o(eng_addr_o), .dptr_q(dptr_q),
  .ack_we(ack_we), .bus_wdata_i(bus_wdata_i), .eng_intr_i(eng_intr_i),
  .raw_q(raw_q), .irq_o(irq_o));

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INTR_W = 4;

  typedef struct packed {
    logic        we;
    logic [1:0]  size;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd2, 16'h0060, 32'h0000_1000, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h0060, 32'h0, 32'h0000_1000, 1'b0},
    '{1'b1, 2'd2, 16'h007C, 32'h0000_2000, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h007C, 32'h0, 32'h0000_2000, 1'b0},
    '{1'b1, 2'd2, 16'h0058, 32'h0000_3000, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h0058, 32'h0, 32'h0000_3000, 1'b0},
    '{1'b1, 2'd2, 16'h005C, 32'h0000_3100, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h005C, 32'h0, 32'h0000_3100, 1'b0},
    '{1'b1, 2'd2, 16'h0000, 32'h0000_0044, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h0000, 32'h0, 32'h0000_0044, 1'b0},
    '{1'b0, 2'd2, 16'h0088, 32'h0, 32'h0000_0101, 1'b0},
    '{1'b1, 2'd2, 16'h0094, 32'h0000_000F, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h0094, 32'h0, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h0040, 32'h0, 32'h0, 1'b0},
    '{1'b1, 2'd0, 16'h0060, 32'h0000_DEAD, 32'h0, 1'b1},
    '{1'b0, 2'd2, 16'h0060, 32'h0, 32'h0000_1000, 1'b0},
    '{1'b0, 2'd2, 16'h2060, 32'h0, 32'h0, 1'b1},
    '{1'b1, 2'd1, 16'h0084, 32'h0000_0003, 32'h0, 1'b1},
    '{1'b0, 2'd2, 16'h0088, 32'h0, 32'h0000_0101, 1'b0},
    '{1'b1, 2'd2, 16'h008C, 32'h0000_000C, 32'h0, 1'b0},
    '{1'b0, 2'd2, 16'h008C, 32'h0, 32'h0000_000C, 1'b0},
    '{1'b0, 2'd2, 16'h0090, 32'h0, 32'h0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_size = 2'd2;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic client = 1'b0;
  logic load_d, load_c, start;
  logic [31:0] eaddr;
  logic done = 1'b0, d_eol = 1'b0, eng_eol = 1'b0;
  logic [31:0] ptr0 = '0, ptr1 = '0;
  logic [INTR_W-1:0] eintr = '0;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(16), .CH_ID(0), .INTR_W(INTR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_size_i(bus_size), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_ack_o(bus_ack), .bus_err_o(bus_err), .bus_rdata_o(bus_rdata),
    .client_i(client), .eng_load_d_o(load_d), .eng_load_c_o(load_c),
    .eng_addr_o(eaddr), .eng_start_o(start), .eng_done_i(done),
    .eng_d_eol_i(d_eol), .eng_ptr0_i(ptr0), .eng_ptr1_i(ptr1),
    .eng_eol_i(eng_eol), .eng_intr_i(eintr), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] sz, input logic [15:0] a,
                      input logic [31:0] d, output logic [31:0] rd, output logic er,
                      output logic ak);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err; ak = bus_ack;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er, ak;
    xfer(1'b1, 2'd2, a, d, rd, er, ak);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er, ak;
    xfer(1'b0, 2'd2, a, 32'h0, rd, er, ak);
    chk(tag, rd, exp);
  endtask

  task automatic reply(input logic [31:0] p0, input logic [31:0] p1, input logic e);
    done = 1'b1; ptr0 = p0; ptr1 = p1; d_eol = e;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd; logic er, ak;
    repeat (3) @(negedge clk);
    chk("R4 reset status irq", {30'd0, irq, bus_ack}, 32'h0);
    chk("R5 reset strobes", {29'd0, load_d, load_c, start}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R4 status after reset", 16'h0088, 32'h101);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i].we, VEC[i].size, VEC[i].addr, VEC[i].wdata, rd, er, ak);
      chk($sformatf("R1 ack vec %0d", i), {31'd0, ak}, 32'd1);
      chk($sformatf("R1 err vec %0d", i), {31'd0, er}, {31'd0, VEC[i].err});
      if (!VEC[i].we) chk($sformatf("R2 rdata vec %0d", i), rd, VEC[i].rdata);
    end

    // R5: data load with burst start
    wr(16'h0084, 32'h1);
    rd_chk("R3 cfg enable keeps RST", 16'h0088, 32'h101);
    client = 1'b1;
    wr(16'h009C, 32'h160);
    chk("R5 load_d strobe", {31'd0, load_d}, 32'd1);
    chk("R5 load_d addr", eaddr, 32'h3000);
    reply(32'h3040, 32'h5000, 1'b1);
    chk("R7 start strobe", {31'd0, start}, 32'd1);
    rd_chk("R7 status running", 16'h0088, 32'h104);
    rd_chk("R5 data pointer", 16'h0000, 32'h3000);

    // R8: continue without reached end-of-list
    wr(16'h0080, 32'h1);
    chk("R8 reload strobe", {31'd0, load_d}, 32'd1);
    chk("R8 reload addr", eaddr, 32'h3000);
    reply(32'h3040, 32'h5800, 1'b0);
    chk("R9 no restart", {30'd0, load_d, start}, 32'd0);
    rd_chk("R9 buf updated", 16'h005C, 32'h5800);

    // R12: engine end-of-list report
    eng_eol = 1'b1; @(negedge clk); eng_eol = 1'b0;
    rd_chk("R12 status eol", 16'h0088, 32'h124);

    // R8: continue, descriptor still end-of-list
    wr(16'h0080, 32'h1);
    chk("R8 reload strobe 2", {31'd0, load_d}, 32'd1);
    reply(32'h3040, 32'h5000, 1'b1);
    chk("R9 stays stopped", {30'd0, load_d, start}, 32'd0);
    rd_chk("R9 status unchanged", 16'h0088, 32'h124);
    rd_chk("R9 buf at start", 16'h005C, 32'h5000);

    // R9: software cleared end-of-list
    wr(16'h0080, 32'h1);
    chk("R8 reload strobe 3", {31'd0, load_d}, 32'd1);
    reply(32'h3040, 32'h5000, 1'b0);
    chk("R9 next fetch strobe", {31'd0, load_d}, 32'd1);
    chk("R9 next fetch addr", eaddr, 32'h3040);
    reply(32'h3080, 32'h6000, 1'b1);
    chk("R9 restart strobe", {31'd0, start}, 32'd1);
    rd_chk("R9 status running", 16'h0088, 32'h104);
    rd_chk("R9 saved desc", 16'h0058, 32'h3040);
    rd_chk("R9 saved buf", 16'h005C, 32'h6000);
    rd_chk("R9 data pointer", 16'h0000, 32'h3040);

    // R3/R8: stopped channel ignores continue
    wr(16'h0084, 32'h3);
    rd_chk("R3 stopped", 16'h0088, 32'h102);
    wr(16'h0080, 32'h1);
    chk("R8 no fetch when stopped", {31'd0, load_d}, 32'd0);
    wr(16'h0084, 32'h2);
    rd_chk("R3 RST wins", 16'h0088, 32'h101);

    // R6: context load
    wr(16'h009C, 32'h200);
    chk("R6 load_c strobe", {31'd0, load_c}, 32'd1);
    chk("R6 load_c addr", eaddr, 32'h2000);
    reply(32'h7000, 32'h7100, 1'b0);
    chk("R6 start", {31'd0, start}, 32'd1);
    rd_chk("R6 status", 16'h0088, 32'h104);
    rd_chk("R6 saved desc", 16'h0058, 32'h7000);
    rd_chk("R6 saved buf", 16'h005C, 32'h7100);

    // R7: no client
    client = 1'b0;
    wr(16'h0084, 32'h3);
    wr(16'h009C, 32'h200);
    chk("R6 load_c strobe 2", {31'd0, load_c}, 32'd1);
    reply(32'h7200, 32'h7300, 1'b0);
    chk("R7 no start without client", {31'd0, start}, 32'd0);
    rd_chk("R7 state kept", 16'h0088, 32'h102);

    // R10/R11: interrupts (mask currently 0xC)
    wr(16'h008C, 32'h4);
    eintr = 4'h5; @(negedge clk); eintr = '0;
    chk("R11 irq on", {31'd0, irq}, 32'd1);
    rd_chk("R10 raw", 16'h0094, 32'h5);
    rd_chk("R11 masked", 16'h0098, 32'h4);
    wr(16'h0090, 32'h4);
    chk("R11 irq off", {31'd0, irq}, 32'd0);
    rd_chk("R10 raw after ack", 16'h0094, 32'h1);
    rd_chk("R10 ack reads zero", 16'h0090, 32'h0);
    wr(16'h008C, 32'h1);
    chk("R11 irq via mask", {31'd0, irq}, 32'd1);
    wr(16'h0090, 32'hF);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);
    rd_chk("R10 raw cleared", 16'h0094, 32'h0);

    // R1: no response without request
    @(negedge clk);
    chk("R1 idle no ack", {30'd0, bus_ack, bus_err}, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule